// File: doc/BRIEF.md
# Private Interrupt Pending and Active Tracker

This block keeps the pending and active state of one processor's sixteen private interrupt lines, which carry interrupt IDs 16 to 31. Each line is set up either as level-sensitive or as edge-triggered, and that choice decides how its pending bit is cleared.

A level line's pending bit simply follows its input. It stays set through an acknowledge and drops when the source deasserts. An edge line latches a rising edge. Its pending bit then survives deassertion of the input and clears only when the line is acknowledged or when software writes its pending-clear bit.

Software reaches the block through a small word-addressed write port and a combinational read port. An interrupt handler acknowledges an ID, which marks the line active. It later signals end-of-interrupt, which clears the active bit. The block always presents the lowest-numbered pending and enabled ID, or the spurious ID 1023 when no line qualifies.

Top module: `ppi_pend_tracker`

## Requirements
- R1: While reset is held, and once it has taken effect, the pending, active, enable and trigger-configuration state is all zero, every line is in level mode, `best_id` is 1023 and `nn_flag` is 0.
- R2: Register address 1 is the trigger word. On write, bit 2i+1 selects edge mode (1) or level mode (0) for line i, which carries ID 16+i. On read, the odd bits return those selections and the even bits return 0.
- R3: Register address 0 is a read-only word. It always reads as zero, and a write to it changes no state.
- R4: A level line's pending bit equals that line's input as sampled at the previous clock edge. An acknowledge does not clear it.
- R5: For an edge line, a rising input sets the pending bit on the next clock. The bit then stays set through deassertion of the input. It clears only when the line's ID is acknowledged, or when a 1 is written to bit 16+i at address 2. If a new rising edge arrives in the same cycle as a clear, the bit stays set.
- R6: An acknowledge of an ID in the range 16..31 sets that line's active bit on the next clock. An end-of-interrupt for an ID clears its active bit. If both target the same line in one cycle, the active bit ends up set. IDs outside 16..31 have no effect.
- R7: `best_id` is 16+i for the lowest i whose pending and enable bits are both set. When no line has both bits set, it is 1023.
- R8: Address 3 holds the line enables in bits 31:16. Reading address 2 returns the pending vector in bits 31:16, with bits 15:0 reading as zero.
- R9: A write to address 1 with any even bit set raises `nn_flag` for exactly the following cycle, to flag an unsupported multi-target request. The even bits are not stored, and the lines keep single-target behaviour.
- R10: Reset asserts asynchronously. After `rst_n` rises, state updates begin only on the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Private interrupt lines; bit i is ID 16+i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being completed |
| pend_o | output | 16 | Pending vector |
| act_o | output | 16 | Active vector |
| best_id | output | 10 | Lowest pending and enabled ID, or 1023 |
| nn_flag | output | 1 | One-cycle unsupported-mode flag |

## Verification
The checker watches several rules on every clock:
- level lines track their sampled input;
- edge lines hold pending until a clear or an acknowledge;
- an acknowledge always produces an active bit;
- `best_id` shows 1023 exactly when nothing is pending and enabled;
- the read-only word reads zero;
- the unsupported-mode flag only follows a trigger-word write.

Only the bench scenarios can show the following:
- that a deasserted edge source stays pending;
- that a same-cycle edge beats a clear;
- that out-of-range IDs are ignored;
- that the reset-release delay holds;
- that the exact lowest-ID choice is made under random mixes of modes, enables, acknowledges and clears.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned ID_W      = 10;
  localparam int unsigned SPURIOUS  = 1023;
  localparam int unsigned WORD_W    = 32;

  typedef enum logic [1:0] {
    ADDR_CFG_RO = 2'd0,
    ADDR_CFG_HI = 2'd1,
    ADDR_PCLR   = 2'd2,
    ADDR_EN     = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ppi_line_cell.sv
// State of one private line: input history, pending and active bits.
module ppi_line_cell (
  input  logic clk,
  input  logic rst_i_n,
  input  logic irq,
  input  logic edge_mode,
  input  logic ack_hit,
  input  logic eoi_hit,
  input  logic sw_clr,
  output logic pend,
  output logic act
);
  logic irq_q;
  logic pend_n;
  logic act_n;
  logic rise;

  always_comb begin
    rise = irq & ~irq_q;
    if (edge_mode) begin
      pend_n = rise | (pend & ~(ack_hit | sw_clr));
    end else begin
      pend_n = irq;
    end
    act_n = ack_hit | (act & ~eoi_hit);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q <= 1'b0;
      pend  <= 1'b0;
      act   <= 1'b0;
    end else begin
      irq_q <= irq;
      pend  <= pend_n;
      act   <= act_n;
    end
  end
endmodule

// File: rtl/ppi_cfg_regs.sv
// Trigger selection, line enables and the unsupported-mode flag.
module ppi_cfg_regs
  import ppi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ID_BASE   = 16
) (
  input  logic                 clk,
  input  logic                 rst_i_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NUM_LINES-1:0] edge_cfg,
  output logic [NUM_LINES-1:0] en,
  output logic [NUM_LINES-1:0] sw_clr,
  output logic                 nn_flag
);
  logic [NUM_LINES-1:0] edge_n;
  logic [NUM_LINES-1:0] en_n;
  logic                 nn_n;
  logic                 cfg_we;
  logic                 en_we;
  logic                 any_even;

  always_comb begin
    cfg_we   = wr_en && (wr_addr == ADDR_CFG_HI);
    en_we    = wr_en && (wr_addr == ADDR_EN);
    any_even = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      edge_n[i] = wr_data[2*i+1];
      any_even  = any_even | wr_data[2*i];
    end
    en_n   = wr_data[ID_BASE +: NUM_LINES];
    sw_clr = (wr_en && (wr_addr == ADDR_PCLR)) ? wr_data[ID_BASE +: NUM_LINES]
                                               : '0;
    nn_n   = cfg_we & any_even;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      edge_cfg <= '0;
      en       <= '0;
      nn_flag  <= 1'b0;
    end else begin
      if (cfg_we) edge_cfg <= edge_n;
      if (en_we)  en       <= en_n;
      nn_flag <= nn_n;
    end
  end
endmodule

// File: rtl/ppi_lowest_sel.sv
// Picks the lowest-numbered requesting line and returns its ID.
module ppi_lowest_sel
  import ppi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ID_BASE   = 16
) (
  input  logic [NUM_LINES-1:0] req,
  output logic [ID_W-1:0]      id
);
  always_comb begin
    id = ID_W'(SPURIOUS);
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) id = ID_W'(ID_BASE + i);
    end
  end
endmodule

// File: rtl/ppi_pend_tracker.sv
module ppi_pend_tracker
  import ppi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ID_BASE   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [1:0]           rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 eoi_valid,
  input  logic [ID_W-1:0]      eoi_id,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] act_o,
  output logic [ID_W-1:0]      best_id,
  output logic                 nn_flag
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_s0;
  logic rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_i_n <= rst_s0;
    end
  end

  logic [NUM_LINES-1:0] edge_cfg;
  logic [NUM_LINES-1:0] en;
  logic [NUM_LINES-1:0] sw_clr;
  logic [NUM_LINES-1:0] ack_hit;
  logic [NUM_LINES-1:0] eoi_hit;

  ppi_cfg_regs #(.NUM_LINES(NUM_LINES), .ID_BASE(ID_BASE)) u_cfg (
    .clk     (clk),
    .rst_i_n (rst_i_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .edge_cfg(edge_cfg),
    .en      (en),
    .sw_clr  (sw_clr),
    .nn_flag (nn_flag)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign ack_hit[g] = ack_valid && (ack_id == ID_W'(ID_BASE + g));
    assign eoi_hit[g] = eoi_valid && (eoi_id == ID_W'(ID_BASE + g));

    ppi_line_cell u_cell (
      .clk      (clk),
      .rst_i_n  (rst_i_n),
      .irq      (irq_in[g]),
      .edge_mode(edge_cfg[g]),
      .ack_hit  (ack_hit[g]),
      .eoi_hit  (eoi_hit[g]),
      .sw_clr   (sw_clr[g]),
      .pend     (pend_o[g]),
      .act      (act_o[g])
    );
  end

  ppi_lowest_sel #(.NUM_LINES(NUM_LINES), .ID_BASE(ID_BASE)) u_sel (
    .req(pend_o & en),
    .id (best_id)
  );

  // Read mux: the trigger word interleaves edge selections on odd bits.
  logic [WORD_W-1:0] cfg_word;

  always_comb begin
    cfg_word = '0;
    for (int i = 0; i < NUM_LINES; i++) cfg_word[2*i+1] = edge_cfg[i];
    rd_data = '0;
    case (rd_addr)
      ADDR_CFG_HI: rd_data = cfg_word;
      ADDR_PCLR:   rd_data[ID_BASE +: NUM_LINES] = pend_o;
      ADDR_EN:     rd_data[ID_BASE +: NUM_LINES] = en;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ppi_pend_tracker_chk.sv
module ppi_pend_tracker_chk
  import ppi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_i_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [NUM_LINES-1:0] edge_cfg,
  input logic [NUM_LINES-1:0] en,
  input logic [NUM_LINES-1:0] sw_clr,
  input logic [NUM_LINES-1:0] ack_hit,
  input logic [NUM_LINES-1:0] pend_o,
  input logic [NUM_LINES-1:0] act_o,
  input logic [ID_W-1:0]      best_id,
  input logic [1:0]           rd_addr,
  input logic [WORD_W-1:0]    rd_data,
  input logic                 wr_en,
  input logic [1:0]           wr_addr,
  input logic                 nn_flag
);
  // Armed once a live update edge has passed since reset release.
  logic armed;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_i_n || !armed)
    ((pend_o ^ $past(irq_in)) & ~$past(edge_cfg)) == '0);

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_i_n || !armed)
    ($past(pend_o & edge_cfg & ~(ack_hit | sw_clr)) & ~pend_o) == '0);

  p_ack_active_r6: assert property (@(posedge clk) disable iff (!rst_i_n || !armed)
    ($past(ack_hit) & ~act_o) == '0);

  p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (((pend_o & en) == '0) == (best_id == ID_W'(SPURIOUS))));

  p_ro_word_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_addr == ADDR_CFG_RO) |-> (rd_data == '0));

  p_nn_source_r9: assert property (@(posedge clk) disable iff (!rst_i_n || !armed)
    nn_flag |-> $past(wr_en && (wr_addr == ADDR_CFG_HI)));
endmodule

bind ppi_pend_tracker ppi_pend_tracker_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk     (clk),
  .rst_i_n (rst_i_n),
  .irq_in  (irq_in),
  .edge_cfg(edge_cfg),
  .en      (en),
  .sw_clr  (sw_clr),
  .ack_hit (ack_hit),
  .pend_o  (pend_o),
  .act_o   (act_o),
  .best_id (best_id),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .nn_flag (nn_flag)
);

// File: tb/ppi_pend_tracker_tb.sv
`timescale 1ns/1ps
module ppi_pend_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        ack_valid;
  logic [9:0]  ack_id;
  logic        eoi_valid;
  logic [9:0]  eoi_id;
  logic [15:0] pend_o;
  logic [15:0] act_o;
  logic [9:0]  best_id;
  logic        nn_flag;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ppi_pend_tracker u_dut (.*);

  // Behavioural reference model
  logic [15:0] m_pend, m_act, m_edge, m_en, m_prev;
  logic        m_nn;
  int          m_live;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_edge = 0; m_en = 0; m_prev = 0; m_nn = 0;
      m_live = 0;
    end else if (m_live < 2) begin
      m_live = m_live + 1;
    end else begin
      logic [15:0] np, na;
      logic        even;
      for (int i = 0; i < 16; i++) begin
        bit ak, eo, sc;
        ak = ack_valid && (int'(ack_id) == 16 + i);
        eo = eoi_valid && (int'(eoi_id) == 16 + i);
        sc = wr_en && wr_addr == 2 && wr_data[16+i];
        if (m_edge[i]) np[i] = (irq_in[i] && !m_prev[i]) || (m_pend[i] && !ak && !sc);
        else           np[i] = irq_in[i];
        na[i] = ak || (m_act[i] && !eo);
      end
      even = 0;
      for (int i = 0; i < 32; i += 2) even = even | wr_data[i];
      m_nn = wr_en && wr_addr == 1 && even;
      if (wr_en && wr_addr == 1) for (int i = 0; i < 16; i++) m_edge[i] = wr_data[2*i+1];
      if (wr_en && wr_addr == 3) m_en = wr_data[31:16];
      m_pend = np; m_act = na; m_prev = irq_in;
    end
  end

  function automatic logic [9:0] m_best();
    for (int i = 0; i < 16; i++) if (m_pend[i] && m_en[i]) return 10'(16 + i);
    return 10'd1023;
  endfunction

  function automatic logic [31:0] m_rd();
    logic [31:0] w = 0;
    case (rd_addr)
      2'd1: for (int i = 0; i < 16; i++) w[2*i+1] = m_edge[i];
      2'd2: w[31:16] = m_pend;
      2'd3: w[31:16] = m_en;
      default: w = 0;
    endcase
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  task automatic cmp_all();
    chk(pend_o == m_pend, "R4 or R5 pending vs model", 32'(pend_o), 32'(m_pend));
    chk(act_o == m_act, "R6 active vs model", 32'(act_o), 32'(m_act));
    chk(best_id == m_best(), "R7 best_id vs model", 32'(best_id), 32'(m_best()));
    chk(nn_flag == m_nn, "R9 nn_flag vs model", 32'(nn_flag), 32'(m_nn));
    chk(rd_data == m_rd(), "R2 R3 R8 read data vs model", rd_data, m_rd());
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle();
    wr_en = 0; ack_valid = 0; eoi_valid = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic ack(input int id);
    ack_valid = 1; ack_id = 10'(id);
    cyc();
    ack_valid = 0;
  endtask

  task automatic eoi(input int id);
    eoi_valid = 1; eoi_id = 10'(id);
    cyc();
    eoi_valid = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; irq_in = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    ack_valid = 0; ack_id = 0; eoi_valid = 0; eoi_id = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pend_o == 0 && act_o == 0, "R1 pending/active zero", {pend_o, act_o}, 0);
    chk(best_id == 10'd1023, "R1 best_id spurious", 32'(best_id), 1023);
    chk(nn_flag == 0, "R1 nn_flag low", 32'(nn_flag), 0);
    // R10 release delay: line 0 is level mode and held high
    rst_n = 1; irq_in[0] = 1;
    cyc(); chk(pend_o[0] == 0, "R10 no update on first edge", 32'(pend_o), 0);
    cyc(); chk(pend_o[0] == 0, "R10 no update on second edge", 32'(pend_o), 0);
    cyc(); chk(pend_o[0] == 1, "R4 level pending after release", 32'(pend_o), 1);
    irq_in[0] = 0; cyc();

    // R3 read-only word
    wr(2'd0, 32'hffff_ffff);
    rd_addr = 2'd0; cyc();
    chk(rd_data == 0, "R3 word 0 reads zero", rd_data, 0);
    rd_addr = 2'd1; #1;
    chk(rd_data == 0, "R3 word 0 write left trigger word", rd_data, 0);

    // R8 enables, R2 trigger word (lines 1 and 3 edge)
    wr(2'd3, 32'hffff_0000);
    rd_addr = 2'd3; #1;
    chk(rd_data == 32'hffff_0000, "R8 enable readback", rd_data, 32'hffff_0000);
    wr(2'd1, 32'h0000_0088);
    rd_addr = 2'd1; #1;
    chk(rd_data == 32'h0000_0088, "R2 trigger readback", rd_data, 32'h88);
    chk(nn_flag == 0, "R9 no flag without even bits", 32'(nn_flag), 0);
    // R9 even bits flagged, not stored
    wr(2'd1, 32'h0000_0555 | 32'h88);
    chk(nn_flag == 1, "R9 flag after even-bit write", 32'(nn_flag), 1);
    rd_addr = 2'd1; #1;
    chk(rd_data == 32'h0000_0088, "R9 even bits read zero", rd_data, 32'h88);
    cyc();
    chk(nn_flag == 0, "R9 flag lasts one cycle", 32'(nn_flag), 0);

    // R4 level line survives acknowledge
    irq_in[0] = 1; cyc();
    chk(best_id == 10'd16, "R7 best is 16", 32'(best_id), 16);
    ack(16);
    chk(act_o[0] == 1, "R6 active after ack", 32'(act_o), 1);
    chk(pend_o[0] == 1, "R4 level stays pending after ack", 32'(pend_o), 1);
    irq_in[0] = 0; cyc();
    chk(pend_o[0] == 0, "R4 level clears on deassert", 32'(pend_o), 0);
    eoi(16);
    chk(act_o[0] == 0, "R6 eoi clears active", 32'(act_o), 0);

    // R5 edge line holds through deassert, clears on ack
    irq_in[1] = 1; cyc(); irq_in[1] = 0; cyc();
    chk(pend_o[1] == 1, "R5 edge holds after deassert", 32'(pend_o), 2);
    rd_addr = 2'd2; #1;
    chk(rd_data == 32'h0002_0000, "R8 pending readback", rd_data, 32'h0002_0000);
    ack(17);
    chk(pend_o[1] == 0 && act_o[1] == 1, "R5 edge ack clears pending", {pend_o, act_o}, 32'h0000_0002);
    // R5 software clear
    irq_in[3] = 1; cyc(); irq_in[3] = 0; cyc();
    wr(2'd2, 32'h0008_0000);
    chk(pend_o[3] == 0, "R5 software clear", 32'(pend_o), 0);
    // R5 new edge wins over same-cycle clear
    irq_in[3] = 1; cyc(); irq_in[3] = 0; cyc();
    irq_in[3] = 1; ack_valid = 1; ack_id = 10'd19; cyc(); ack_valid = 0;
    chk(pend_o[3] == 1, "R5 rising edge beats ack", 32'(pend_o), 32'h8);
    irq_in[3] = 0;
    // R6 out-of-range ID ignored, ack+eoi same line
    ack(5);
    chk(act_o == 16'h000a, "R6 out-of-range ack ignored", 32'(act_o), 32'ha);
    ack_valid = 1; ack_id = 10'd20; eoi_valid = 1; eoi_id = 10'd20; cyc(); idle();
    chk(act_o[4] == 1, "R6 ack wins over eoi", 32'(act_o), 32'h1a);
    // R7 disabled pending line is not chosen
    wr(2'd3, 32'h0000_0000);
    chk(best_id == 10'd1023, "R7 disabled pending gives spurious", 32'(best_id), 1023);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      irq_in    = (r[3:0] < 4) ? 16'($urandom) : irq_in;
      wr_en     = (r[7:4] == 0);
      wr_addr   = r[9:8];
      wr_data   = $urandom;
      rd_addr   = r[11:10];
      ack_valid = r[14:12] == 0;
      ack_id    = (r[15]) ? 10'(16 + ($urandom % 16)) : 10'($urandom % 40);
      eoi_valid = r[18:16] == 0;
      eoi_id    = 10'(14 + ($urandom % 20));
      cyc();
    end
    idle();
    cyc();
    summary();
  end
endmodule